// File: doc/BRIEF.md
# Multi-Group Event Interrupt Router

This block gathers ninety-six single-cycle peripheral event pulses into sticky status bits and steers them onto three level-sensitive processor interrupt lines. Each event occupies one bit of three 32-bit status words. Event n lives in word n/32 at bit n%32. Software acknowledges an event by writing a 1 to its status bit. Writing 0 leaves a bit alone.

Every output line owns a full set of three 32-bit enable masks that spans all ninety-six events, so any event can reach any combination of lines. A line is raised when at least one of its enabled events is pending. For each line a read-only vector word names the lowest-numbered event that is both pending and enabled on that line, so the handler can find the source without scanning status itself. All registers sit behind a simple 32-bit word bus with a write strobe and a combinational read port.

Top module: `evt_irq_router`

## Requirements
- R1: After reset every status bit and every mask bit reads 0 and all three irq_out lines are 0.
- R2: An event pulse on evt_in[n] at a rising edge sets status bit n (word n/32, bit n%32, word w read at address 4*w) at that edge, and the bit stays set until cleared.
- R3: A bus write to status word w clears exactly the bits written as 1; bits written as 0 keep their value.
- R4: When evt_in[n] is high in the same cycle as a write that clears bit n, the bit ends up set.
- R5: A mask bit of 1 enables its event on that line and 0 disables it; mask writes never change any status bit, and a pending event whose mask bit is 0 never raises the line.
- R6: irq_out[l] is registered: at each rising edge it takes the value "some status bit AND line l's mask bit is 1" as held in the registers just before that edge.
- R7: Line l (0 to 2) is driven only by its own masks, found at address 0x10*(l+1) + 4*w for status word w; an event enabled only for line 2 raises irq_out[2] alone.
- R8: The vector word of line l reads at 0x40 + 4*l; bit 31 is 1 when line l has any pending enabled event, bits 6:0 hold the lowest such event number (0 to 95), all other bits are 0; with nothing pending the word is 0.
- R9: Writes to the vector words have no effect, and reads of unmapped word addresses (such as 0x0C and 0x4C) return 0.
- R10: Every mask word reads back the value last written to it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_in | input | 96 | Single-cycle event pulses, one per source |
| bus_wr | input | 1 | Write strobe for the register bus |
| bus_addr | input | 8 | Byte address of the accessed word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| irq_out | output | 3 | Registered interrupt request lines |

## Verification
On every cycle the assertions check that a pulsed event lands in status, that no status bit drops unless a 1 was written to it, that an acknowledge without a coincident pulse really clears, that status is frozen when neither pulses nor acknowledges occur, that each line follows the previous cycle's encoder result and that vector numbers stay in range. Only the bench scenarios show the address map, the lowest-index choice across words, the independence of the three lines, mask readback and the ignored vector writes, because those depend on which registers software addressed.

// File: rtl/evt_router_pkg.sv
package evt_router_pkg;
  localparam int DEF_WORDS  = 3;
  localparam int DEF_WORD_W = 32;
  localparam int DEF_LINES  = 3;
  localparam int BUS_W      = 32;

  // Region of the address map selected by a byte address.
  function automatic logic [3:0] addr_area(input logic [7:0] a);
    return a[7:4];
  endfunction

  // Word within a region.
  function automatic logic [1:0] addr_word(input logic [7:0] a);
    return a[3:2];
  endfunction
endpackage

// File: rtl/evt_status_bank.sv
module evt_status_bank #(
  parameter int TOT = 96
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [TOT-1:0] evt_in,
  input  logic [TOT-1:0] clr_mask,
  output logic [TOT-1:0] status_q
);
  // Pulses take priority over acknowledges.
  function automatic logic [TOT-1:0] next_status(input logic [TOT-1:0] cur,
                                                 input logic [TOT-1:0] clr,
                                                 input logic [TOT-1:0] set);
    return (cur & ~clr) | set;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status_q <= '0;
    else        status_q <= next_status(status_q, clr_mask, evt_in);
  end
endmodule

// File: rtl/evt_mask_matrix.sv
module evt_mask_matrix #(
  parameter int WORDS  = 3,
  parameter int WORD_W = 32,
  parameter int LINES  = 3
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [LINES*WORDS-1:0]          we,
  input  logic [WORD_W-1:0]               wdata,
  output logic [LINES*WORDS*WORD_W-1:0]   mask_q
);
  // Slot g = line*WORDS + word, so line l occupies a contiguous slice.
  for (genvar g = 0; g < LINES*WORDS; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     mask_q[g*WORD_W +: WORD_W] <= '0;
      else if (we[g]) mask_q[g*WORD_W +: WORD_W] <= wdata;
    end
  end
endmodule

// File: rtl/evt_line_encoder.sv
module evt_line_encoder #(
  parameter int TOT   = 96,
  parameter int NUM_W = 7
) (
  input  logic [TOT-1:0]   pend,
  output logic             valid,
  output logic [NUM_W-1:0] num
);
  function automatic logic [NUM_W-1:0] lowest_index(input logic [TOT-1:0] v);
    logic [NUM_W-1:0] r;
    r = '0;
    for (int i = TOT - 1; i >= 0; i--) begin
      if (v[i]) r = NUM_W'(i);
    end
    return r;
  endfunction

  assign valid = |pend;
  assign num   = lowest_index(pend);
endmodule

// File: rtl/evt_irq_router.sv
module evt_irq_router
  import evt_router_pkg::*;
#(
  parameter int WORDS  = DEF_WORDS,
  parameter int WORD_W = DEF_WORD_W,
  parameter int LINES  = DEF_LINES
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [WORDS*WORD_W-1:0] evt_in,
  input  logic                    bus_wr,
  input  logic [7:0]              bus_addr,
  input  logic [BUS_W-1:0]        bus_wdata,
  output logic [BUS_W-1:0]        bus_rdata,
  output logic [LINES-1:0]        irq_out
);
  localparam int TOT   = WORDS * WORD_W;
  localparam int NUM_W = $clog2(TOT);
  localparam int VEC_AREA = LINES + 1;

  logic [3:0] area;
  logic [1:0] widx;
  assign area = addr_area(bus_addr);
  assign widx = addr_word(bus_addr);

  // Named internal events for the checker.
  logic [TOT-1:0]            clr_mask;
  logic [TOT-1:0]            status_q;
  logic [LINES*WORDS-1:0]    mask_we;
  logic [LINES*TOT-1:0]      mask_q;
  logic [LINES-1:0]          line_valid;
  logic [LINES*NUM_W-1:0]    line_num;
  logic [LINES-1:0]          irq_q;

  // Acknowledge decode: one status word per region-0 slot.
  for (genvar w = 0; w < WORDS; w++) begin : g_clr
    assign clr_mask[w*WORD_W +: WORD_W] =
      (bus_wr && area == 4'd0 && widx == 2'(w)) ? bus_wdata[WORD_W-1:0] : '0;
  end

  // Mask write decode: line l lives in region l+1.
  for (genvar l = 0; l < LINES; l++) begin : g_mwe
    for (genvar w = 0; w < WORDS; w++) begin : g_w
      assign mask_we[l*WORDS + w] = bus_wr && area == 4'(l + 1) && widx == 2'(w);
    end
  end

  evt_status_bank #(.TOT(TOT)) u_status (
    .clk      (clk),
    .rst_n    (rst_n),
    .evt_in   (evt_in),
    .clr_mask (clr_mask),
    .status_q (status_q)
  );

  evt_mask_matrix #(.WORDS(WORDS), .WORD_W(WORD_W), .LINES(LINES)) u_mask (
    .clk    (clk),
    .rst_n  (rst_n),
    .we     (mask_we),
    .wdata  (bus_wdata[WORD_W-1:0]),
    .mask_q (mask_q)
  );

  for (genvar l = 0; l < LINES; l++) begin : g_line
    evt_line_encoder #(.TOT(TOT), .NUM_W(NUM_W)) u_enc (
      .pend  (status_q & mask_q[l*TOT +: TOT]),
      .valid (line_valid[l]),
      .num   (line_num[l*NUM_W +: NUM_W])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= '0;
    else        irq_q <= line_valid;
  end
  assign irq_out = irq_q;

  function automatic logic [BUS_W-1:0] vector_word(input logic v,
                                                   input logic [NUM_W-1:0] n);
    return {v, {(BUS_W-1-NUM_W){1'b0}}, n};
  endfunction

  always_comb begin
    bus_rdata = '0;
    for (int w = 0; w < WORDS; w++) begin
      if (area == 4'd0 && widx == 2'(w))
        bus_rdata = BUS_W'(status_q[w*WORD_W +: WORD_W]);
    end
    for (int l = 0; l < LINES; l++) begin
      for (int w = 0; w < WORDS; w++) begin
        if (area == 4'(l + 1) && widx == 2'(w))
          bus_rdata = BUS_W'(mask_q[(l*WORDS + w)*WORD_W +: WORD_W]);
      end
      if (area == 4'(VEC_AREA) && widx == 2'(l))
        bus_rdata = vector_word(line_valid[l], line_num[l*NUM_W +: NUM_W]);
    end
  end
endmodule

// File: rtl/evt_router_checks.sv
module evt_router_checks #(
  parameter int TOT   = 96,
  parameter int LINES = 3,
  parameter int NUM_W = 7
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [TOT-1:0]       evt_in,
  input logic [TOT-1:0]       clr_mask,
  input logic [TOT-1:0]       status_q,
  input logic [LINES-1:0]     line_valid,
  input logic [LINES*NUM_W-1:0] line_num,
  input logic [LINES-1:0]     irq_out
);
  assert_evt_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt_in) |=> ((status_q & $past(evt_in)) == $past(evt_in)));

  assert_no_spurious_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((($past(status_q) & ~$past(clr_mask)) & ~status_q) == '0));

  assert_clear_takes_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (|(clr_mask & ~evt_in)) |=> ((status_q & $past(clr_mask & ~evt_in)) == '0));

  assert_set_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (|(clr_mask & evt_in)) |=> ((status_q & $past(clr_mask & evt_in)) == $past(clr_mask & evt_in)));

  assert_status_frozen_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_in == '0 && clr_mask == '0) |=> $stable(status_q));

  assert_line_registered_R6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq_out == $past(line_valid)));

  for (genvar l = 0; l < LINES; l++) begin : g_rng
    assert_vector_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
      line_valid[l] |-> (int'(line_num[l*NUM_W +: NUM_W]) < TOT));
  end
endmodule

bind evt_irq_router evt_router_checks #(.TOT(TOT), .LINES(LINES), .NUM_W(NUM_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .evt_in     (evt_in),
  .clr_mask   (clr_mask),
  .status_q   (status_q),
  .line_valid (line_valid),
  .line_num   (line_num),
  .irq_out    (irq_out)
);

// File: tb/evt_irq_router_test.sv
`timescale 1ns/1ps
module evt_irq_router_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [95:0] evt_in = '0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [2:0]  irq_out;

  evt_irq_router uut (
    .clk(clk), .rst_n(rst_n), .evt_in(evt_in), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_out(irq_out)
  );

  always #2.5 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // Behavioural reference state.
  bit [95:0] ref_status = '0;
  bit [95:0] ref_mask [3];
  bit [2:0]  ref_irq = '0;

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic bit [31:0] ref_read(input bit [7:0] a);
    int area = a[7:4];
    int w = a[3:2];
    if (w > 2) return 32'h0;
    if (area == 0) return ref_status[w*32 +: 32];
    if (area >= 1 && area <= 3) return ref_mask[area-1][w*32 +: 32];
    if (area == 4) begin
      for (int i = 0; i < 96; i++)
        if (ref_status[i] && ref_mask[w][i]) return 32'h8000_0000 | i;
      return 32'h0;
    end
    return 32'h0;
  endfunction

  task automatic tick(input bit [95:0] evt, input bit wr, input bit [7:0] a,
                      input bit [31:0] d);
    int area;
    int w;
    @(negedge clk);
    evt_in = evt; bus_wr = wr; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    for (int l = 0; l < 3; l++) ref_irq[l] = |(ref_status & ref_mask[l]);
    area = a[7:4];
    w = a[3:2];
    if (wr && w <= 2) begin
      if (area == 0) ref_status[w*32 +: 32] &= ~d;
      else if (area >= 1 && area <= 3) ref_mask[area-1][w*32 +: 32] = d;
    end
    ref_status |= evt;
    #1;
    check(irq_out === ref_irq, "R6 per-cycle line", 32'(irq_out), 32'(ref_irq));
    check(bus_rdata === ref_read(a), "R10 per-cycle read", bus_rdata, ref_read(a));
  endtask

  task automatic wr(input bit [7:0] a, input bit [31:0] d);
    tick('0, 1'b1, a, d);
  endtask

  task automatic rd(input bit [7:0] a, input bit [31:0] exp, input string tag);
    tick('0, 1'b0, a, 32'h0);
    check(bus_rdata === exp, tag, bus_rdata, exp);
  endtask

  task automatic line_is(input bit [2:0] exp, input string tag);
    tick('0, 1'b0, 8'h00, 32'h0);
    check(irq_out === exp, tag, 32'(irq_out), 32'(exp));
  endtask

  initial begin
    for (int l = 0; l < 3; l++) ref_mask[l] = '0;
    repeat (3) @(posedge clk);
    #1;
    check(irq_out === 3'b000, "R1 lines in reset", 32'(irq_out), 0);
    @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state of status and masks
    rd(8'h00, 32'h0, "R1 status0");
    rd(8'h08, 32'h0, "R1 status2");
    rd(8'h14, 32'h0, "R1 mask line0 word1");
    rd(8'h38, 32'h0, "R1 mask line2 word2");

    // R2: pulses set sticky status
    tick((96'd1 << 3) | (96'd1 << 40), 1'b0, 8'h00, 32'h0);
    rd(8'h00, 32'h0000_0008, "R2 status0 after pulse");
    rd(8'h04, 32'h0000_0100, "R2 status1 after pulse");
    line_is(3'b000, "R5 masked events keep lines low");

    // R6 / R8: enable event 3 on line 0
    wr(8'h10, 32'h0000_0008);
    line_is(3'b001, "R6 line0 raised");
    rd(8'h40, 32'h8000_0003, "R8 vector line0");

    // R3: zero write keeps, one write clears
    wr(8'h00, 32'h0000_0000);
    rd(8'h00, 32'h0000_0008, "R3 zero write keeps bit");
    wr(8'h00, 32'h0000_0008);
    rd(8'h00, 32'h0000_0000, "R3 one write clears bit");
    line_is(3'b000, "R6 line0 drops after ack");

    // R4: pulse and clear together
    tick(96'd1 << 3, 1'b1, 8'h00, 32'h0000_0008);
    rd(8'h00, 32'h0000_0008, "R4 set wins over clear");

    // R5: clearing mask leaves status
    wr(8'h10, 32'h0000_0000);
    rd(8'h00, 32'h0000_0008, "R5 mask clear keeps status");
    line_is(3'b000, "R5 disabled event drops line");

    // R8: lowest within one word
    tick((96'd1 << 5) | (96'd1 << 1), 1'b0, 8'h00, 32'h0);
    wr(8'h10, 32'h0000_0022);
    rd(8'h40, 32'h8000_0001, "R8 lowest within word");
    wr(8'h10, 32'h0000_0000);

    // R7: event 70 routed to line 2 only
    tick(96'd1 << 70, 1'b0, 8'h00, 32'h0);
    wr(8'h38, 32'h0000_0040);
    line_is(3'b100, "R7 only line2 raised");
    rd(8'h48, 32'h8000_0046, "R8 vector line2 event 70");
    rd(8'h40, 32'h0000_0000, "R8 idle line0 vector");

    // R8: lowest across words on line 1
    wr(8'h24, 32'h0000_0100);
    wr(8'h28, 32'h0000_0040);
    rd(8'h44, 32'h8000_0028, "R8 lowest across words");
    line_is(3'b110, "R7 lines 1 and 2 raised");
    wr(8'h04, 32'h0000_0100);
    rd(8'h44, 32'h8000_0046, "R8 next after ack");

    // R9: vector writes ignored, unmapped reads zero
    wr(8'h44, 32'hFFFF_FFFF);
    rd(8'h44, 32'h8000_0046, "R9 vector write ignored");
    rd(8'h00, 32'h0000_002A, "R9 vector write leaves status");
    rd(8'h4C, 32'h0000_0000, "R9 unmapped vector slot");
    rd(8'h0C, 32'h0000_0000, "R9 unmapped status slot");

    // R10: mask readback
    wr(8'h34, 32'hA5A5_0F0F);
    rd(8'h34, 32'hA5A5_0F0F, "R10 mask readback");
    rd(8'h28, 32'h0000_0040, "R10 line1 word2 readback");

    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule